// File: doc/BRIEF.md
# Multi-drop Serial Receiver with Masked Address Filter

This block receives asynchronous serial frames of one start bit, eight data bits, a ninth bit and one stop bit. It times each frame from a tick that runs at sixteen times the bit rate. It votes on three samples at the middle of every bit, gathers the nine bits least significant first, and makes its decision at the middle of the stop bit. At that point it can load the eight data bits and the ninth bit into holding registers and raise a ready flag.

In a multi-drop network the ninth bit marks an address frame. With the filter enabled, the block accepts only address frames whose byte matches the station's own address or its broadcast address. Data frames and foreign addresses never disturb the holding registers or the ready flag. A mask register turns any address bit into a don't-care. With the filter disabled, every frame is accepted whenever the ready flag is clear. A stop bit sampled as 0 sets a sticky framing-error flag.

Top module: `mpuart_rx`

## Requirements
- R1: While idle, a falling edge on the synchronized line at a baud tick (the previous tick saw 1, this tick sees 0) starts a frame. This tick is sub-sample 0. The start bit is kept only if the majority of sub-samples 7, 8 and 9 is 0. Otherwise the receiver returns to idle with no flag change.
- R2: Bits are received least significant first. The eight data bits go to `rx_data` and the ninth bit goes to `rx_bit9`.
- R3: The accept decision and the framing-error decision are made at sub-sample 9 of the stop bit. `rx_rdy` and `frame_err` change on the clock edge of that tick.
- R4: A frame is never accepted while `rx_rdy` is 1. `rx_data` and `rx_bit9` then keep their values.
- R5: With `filt_en`=0, every completed frame is accepted while `rx_rdy` is 0, whatever its ninth bit is.
- R6: With `filt_en`=1, a frame whose ninth bit is 0 is never accepted.
- R7: With `filt_en`=1, a frame with ninth bit 1 is accepted if the byte equals `own_addr` in every bit where `addr_mask` is 1. Bits where the mask is 0 are don't-care.
- R8: With `filt_en`=1, a frame with ninth bit 1 is also accepted if the byte has a 1 in every bit where `own_addr | addr_mask` is 1 (broadcast).
- R9: A stop-bit majority of 0 sets `frame_err`, whether or not the frame is accepted. `frame_err` stays set until `clr_ferr` is 1.
- R10: `rx_rdy` is set only by an accepted frame and cleared only by `clr_rdy`. When both happen in the same cycle, the set wins.
- R11: After the stop-bit decision the receiver hunts again. It needs a sampled 1 before a 0 counts as a start, so a line held low after a bad stop bit starts no frame.
- R12: `rx_en`=0 returns the receiver to idle at the next clock and abandons any partial frame, with no flag change.
- R13: After reset `rx_rdy`, `frame_err`, `rx_data` and `rx_bit9` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| filt_en | input | 1 | Address filter mode |
| own_addr | input | DW | Station address |
| addr_mask | input | DW | Address mask, 0 = don't-care |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| rxd | input | 1 | Serial input, idle high |
| clr_rdy | input | 1 | Clear ready flag |
| clr_ferr | input | 1 | Clear framing-error flag |
| rx_data | output | DW | Received data byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_rdy | output | 1 | Frame accepted flag |
| frame_err | output | 1 | Sticky framing error |

## Verification
The bench builds the block with its defaults: DW=8, OSR=16 and SYNC_STAGES=2. It drives one baud tick every fourth clock, so every bit lasts 64 clocks. The idle clocks between ticks test that all timing advances on ticks only. Line changes that fall between ticks reach the sampler with the full two-stage synchronizer delay. With a 16x oversample the three voting sub-samples sit well inside a bit. This brings within reach a three-tick glitch that gets past the edge detector but loses the vote. An address/mask pair with one don't-care bit separates own-address hits, broadcast hits and misses.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/mpuart_rx_fsm.sv
module mpuart_rx_fsm
  import mpuart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int NB  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd_s,
  output logic          done,
  output logic          stop_bit,
  output logic [NB-1:0] frame
);
  localparam int CW  = $clog2(OSR);
  localparam int IW  = $clog2(NB + 1);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] V0_AT    = CW'(MID - 1);
  localparam logic [CW-1:0] V1_AT    = CW'(MID);
  localparam logic [CW-1:0] DEC_AT   = CW'(MID + 1);
  localparam logic [CW-1:0] LAST_SUB = CW'(OSR - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NB);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          prev_hi;
  logic          v0, v1;
  logic [NB-1:0] shreg;
  logic          vote;

  assign vote     = maj3(v0, v1, rxd_s);
  assign done     = tick && (st == ST_STOP) && (cnt == DEC_AT);
  assign stop_bit = vote;
  assign frame    = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      prev_hi <= 1'b0;
      v0      <= 1'b1;
      v1      <= 1'b1;
      shreg   <= '0;
    end else if (!en) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      prev_hi <= 1'b0;
    end else if (tick) begin
      if (st == ST_IDLE) begin
        prev_hi <= rxd_s;
        if (prev_hi && !rxd_s) begin
          st  <= ST_START;
          cnt <= CW'(1);
        end
      end else begin
        if (cnt == LAST_SUB) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
        if (cnt == V0_AT) v0 <= rxd_s;
        if (cnt == V1_AT) v1 <= rxd_s;
        if (cnt == DEC_AT) begin
          case (st)
            ST_START: if (vote) begin
              st      <= ST_IDLE;
              prev_hi <= 1'b1;
              cnt     <= '0;
            end
            ST_DATA: begin
              shreg <= {vote, shreg[NB-1:1]};
              idx   <= idx + 1'b1;
            end
            ST_STOP: begin
              st      <= ST_IDLE;
              prev_hi <= vote;
              cnt     <= '0;
            end
            default: ;
          endcase
        end
        if (cnt == LAST_SUB) begin
          if (st == ST_START) begin
            st  <= ST_DATA;
            idx <= '0;
          end else if (st == ST_DATA && idx == LAST_IDX) begin
            st <= ST_STOP;
          end
        end
      end
    end
  end

  // R12: disabling forces the hunt state at the next edge
  assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (rst)
    !en |=> st == ST_IDLE);

endmodule

// File: rtl/mpuart_addr_match.sv
module mpuart_addr_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] own,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] bcast;
  logic         own_hit, bc_hit;

  assign bcast   = own | mask;
  assign own_hit = ((rx_byte ^ own) & mask) == '0;
  assign bc_hit  = (~rx_byte & bcast) == '0;
  assign hit     = own_hit | bc_hit;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DW          = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          filt_en,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic          clr_rdy,
  input  logic          clr_ferr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_rdy,
  output logic          frame_err
);
  localparam int NB = DW + 1;

  logic          rxd_s;
  logic          frm_done;
  logic          frm_stop;
  logic [NB-1:0] frm_word;
  logic          addr_hit;
  logic          accept;

  mpuart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
  );

  mpuart_rx_fsm #(.OSR(OSR), .NB(NB)) u_fsm (
    .clk(clk), .rst(rst), .en(rx_en), .tick(baud_tick), .rxd_s(rxd_s),
    .done(frm_done), .stop_bit(frm_stop), .frame(frm_word)
  );

  mpuart_addr_match #(.W(DW)) u_match (
    .rx_byte(frm_word[DW-1:0]), .own(own_addr), .mask(addr_mask), .hit(addr_hit)
  );

  assign accept = frm_done && !rx_rdy &&
                  (!filt_en || (frm_word[DW] && addr_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      rx_rdy    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (accept) begin
        rx_data <= frm_word[DW-1:0];
        rx_bit9 <= frm_word[DW];
        rx_rdy  <= 1'b1;
      end else if (clr_rdy) begin
        rx_rdy <= 1'b0;
      end
      if (frm_done && !frm_stop) frame_err <= 1'b1;
      else if (clr_ferr)         frame_err <= 1'b0;
    end
  end

  // R3: the flag only rises on a stop-bit decision
  assert_rdy_on_stop_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_rdy) |-> $past(frm_done));

  // R4: holding registers frozen while the flag is up
  assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_rdy) && rx_rdy) |-> ($stable(rx_data) && $stable(rx_bit9)));

  // R6: under filtering only matching address frames land
  assert_filter_addr_only_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_rdy) && $past(filt_en)) |-> (rx_bit9 && $past(addr_hit)));

  // R9: framing error is sticky until cleared
  assert_ferr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_err) && !$past(clr_ferr)) |-> frame_err);

  // R10: flag falls only by a clear request
  assert_rdy_clear_only_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_rdy) |-> $past(clr_rdy));

endmodule

// File: tb/mpuart_rx_test.sv
module mpuart_rx_test;
  localparam int DW   = 8;
  localparam int OSR  = 16;
  localparam int MID  = OSR / 2;
  localparam int TDIV = 4;
  localparam int BITC = OSR * TDIV;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_en = 1'b0;
  logic          filt_en = 1'b0;
  logic [DW-1:0] own_addr = '0;
  logic [DW-1:0] addr_mask = '0;
  logic          baud_tick = 1'b0;
  logic          rxd = 1'b1;
  logic          clr_rdy = 1'b0;
  logic          clr_ferr = 1'b0;
  logic [DW-1:0] rx_data;
  logic          rx_bit9;
  logic          rx_rdy;
  logic          frame_err;

  int errors = 0;
  int checks = 0;
  int shown  = 0;

  mpuart_rx #(.DW(DW), .OSR(OSR), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .filt_en(filt_en),
    .own_addr(own_addr), .addr_mask(addr_mask), .baud_tick(baud_tick),
    .rxd(rxd), .clr_rdy(clr_rdy), .clr_ferr(clr_ferr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_rdy(rx_rdy), .frame_err(frame_err)
  );

  always #2 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv      = (tdiv + 1) % TDIV;
    baud_tick = (tdiv == 0);
  end

  // ---------------- behavioural reference model ----------------
  int q[$] = '{1, 1};
  int m_st = 0, m_cnt = 0, m_idx = 0, m_prev = 0, m_v0 = 1, m_v1 = 1;
  int m_word = 0, m_rdy = 0, m_ferr = 0, m_data = 0, m_b9 = 0;

  function automatic bit addr_ok(int b, int a, int m);
    bit own_ok = 1, bc_ok = 1;
    for (int i = 0; i < DW; i++) begin
      if (m[i] && (b[i] != a[i])) own_ok = 0;
      if ((a[i] | m[i]) && !b[i]) bc_ok = 0;
    end
    return own_ok || bc_ok;
  endfunction

  always @(posedge clk) begin
    int s, b, c, st0;
    bit set_r, set_f;
    set_r = 0; set_f = 0;
    if (rst) begin
      q = '{1, 1};
      m_st = 0; m_cnt = 0; m_idx = 0; m_prev = 0; m_v0 = 1; m_v1 = 1;
      m_word = 0; m_rdy = 0; m_ferr = 0; m_data = 0; m_b9 = 0;
    end else begin
      s = q[1];
      if (!rx_en) begin
        m_st = 0; m_prev = 0; m_cnt = 0;
      end else if (baud_tick) begin
        if (m_st == 0) begin
          if (m_prev == 1 && s == 0) begin m_st = 1; m_cnt = 1; end
          m_prev = s;
        end else begin
          c = m_cnt; st0 = m_st;
          m_cnt = (c == OSR - 1) ? 0 : c + 1;
          if (c == MID - 1) m_v0 = s;
          if (c == MID) m_v1 = s;
          if (c == MID + 1) begin
            b = ((m_v0 + m_v1 + s) >= 2) ? 1 : 0;
            if (st0 == 1 && b == 1) begin m_st = 0; m_prev = 1; m_cnt = 0; end
            if (st0 == 2) begin m_word = m_word | (b << m_idx); m_idx++; end
            if (st0 == 3) begin
              m_st = 0; m_prev = b; m_cnt = 0;
              if (b == 0) set_f = 1;
              if (!m_rdy && (!filt_en ||
                  (((m_word >> 8) & 1) == 1 && addr_ok(m_word & 255, own_addr, addr_mask))))
                set_r = 1;
            end
          end
          if (c == OSR - 1) begin
            if (st0 == 1) begin m_st = 2; m_idx = 0; m_word = 0; end
            else if (st0 == 2 && m_idx == 9) m_st = 3;
          end
        end
      end
      if (set_r) begin m_rdy = 1; m_data = m_word & 255; m_b9 = (m_word >> 8) & 1; end
      else if (clr_rdy) m_rdy = 0;
      if (set_f) m_ferr = 1;
      else if (clr_ferr) m_ferr = 0;
      q = '{rxd, q[0]};
    end
  end

  // every-clock comparison: covers R1 R2 R3 R5 R10 R11 R12 timing
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rx_rdy !== m_rdy[0] || frame_err !== m_ferr[0] ||
          rx_data !== m_data[7:0] || rx_bit9 !== m_b9[0]) begin
        errors++;
        if (shown < 10) begin
          shown++;
          $display("FAIL R3 model t=%0t actual rdy=%0b ferr=%0b data=%02h b9=%0b expected rdy=%0d ferr=%0d data=%02h b9=%0d",
                   $time, rx_rdy, frame_err, rx_data, rx_bit9, m_rdy, m_ferr, m_data, m_b9);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_clr_rdy();
    clr_rdy = 1'b1; @(negedge clk); clr_rdy = 1'b0; @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rxd = 1'b1; repeat (n * BITC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stopv,
                      input int abort_at, input logic tail);
    logic [10:0] f;
    f = {stopv, b9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      if (i == abort_at) rx_en = 1'b0;
      rxd = f[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = tail;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R13 rdy", rx_rdy, 0);
    chk("R13 ferr", frame_err, 0);
    chk("R13 data", rx_data, 0);
    chk("R13 b9", rx_bit9, 0);
    rst = 1'b0;
    rx_en = 1'b1;
    idle_bits(2);

    // filter off, plain frame
    send(8'hA5, 1'b1, 1'b1, -1, 1'b1);
    chk("R2 data", rx_data, 'hA5);
    chk("R2 b9", rx_bit9, 1);
    chk("R5 rdy", rx_rdy, 1);

    // flag still up: no overwrite
    send(8'h3C, 1'b0, 1'b1, -1, 1'b1);
    chk("R4 data kept", rx_data, 'hA5);
    chk("R4 b9 kept", rx_bit9, 1);
    pulse_clr_rdy();
    chk("R10 cleared", rx_rdy, 0);
    send(8'h3C, 1'b0, 1'b1, -1, 1'b1);
    chk("R5 data b9=0", rx_data, 'h3C);
    chk("R5 b9", rx_bit9, 0);

    // filter on: addr C0, mask FD
    filt_en = 1'b1; own_addr = 8'hC0; addr_mask = 8'hFD;
    pulse_clr_rdy();
    send(8'hC0, 1'b0, 1'b1, -1, 1'b1);
    chk("R6 data frame ignored", rx_rdy, 0);
    chk("R6 data unchanged", rx_data, 'h3C);
    send(8'hC2, 1'b1, 1'b1, -1, 1'b1);
    chk("R7 dont-care hit rdy", rx_rdy, 1);
    chk("R7 dont-care hit data", rx_data, 'hC2);
    pulse_clr_rdy();
    send(8'hC4, 1'b1, 1'b1, -1, 1'b1);
    chk("R7 miss rdy", rx_rdy, 0);
    send(8'hFD, 1'b1, 1'b1, -1, 1'b1);
    chk("R8 broadcast rdy", rx_rdy, 1);
    chk("R8 broadcast data", rx_data, 'hFD);

    // framing error, line held low afterwards
    filt_en = 1'b0;
    pulse_clr_rdy();
    send(8'h55, 1'b0, 1'b0, -1, 1'b0);
    chk("R9 ferr set", frame_err, 1);
    chk("R9 accepted anyway", rx_data, 'h55);
    rxd = 1'b0;
    pulse_clr_rdy();
    repeat (2 * BITC) @(negedge clk);
    idle_bits(12);
    chk("R11 no frame from held-low line", rx_rdy, 0);
    chk("R9 ferr sticky", frame_err, 1);
    clr_ferr = 1'b1; @(negedge clk); clr_ferr = 1'b0; @(negedge clk);
    chk("R9 ferr cleared", frame_err, 0);
    send(8'h81, 1'b0, 1'b1, -1, 1'b1);
    chk("R11 next frame data", rx_data, 'h81);

    // glitch: three ticks low
    pulse_clr_rdy();
    rxd = 1'b0; repeat (3 * TDIV) @(negedge clk);
    idle_bits(13);
    chk("R1 false start no flag", rx_rdy, 0);
    send(8'h6E, 1'b1, 1'b1, -1, 1'b1);
    chk("R1 real start data", rx_data, 'h6E);

    // set wins over a held clear request (R10)
    clr_rdy = 1'b1;
    send(8'h19, 1'b0, 1'b1, -1, 1'b1);
    clr_rdy = 1'b0;
    @(negedge clk);
    chk("R10 set beats clear data", rx_data, 'h19);

    // abort by disable
    pulse_clr_rdy();
    send(8'hF0, 1'b0, 1'b1, 4, 1'b1);
    idle_bits(1);
    rx_en = 1'b1;
    idle_bits(13);
    chk("R12 aborted frame no flag", rx_rdy, 0);
    chk("R12 data unchanged", rx_data, 'h19);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule